// File: doc/BRIEF.md
# Half-Bridge Dead-Time Sequencer

This block sits between a fault supervisor and the gate drivers of three half-bridge legs. Each leg joins a high-side and a low-side switch at one output node. The supervisor presents a per-switch enable word. The sequencer turns that word into six gate signals and guarantees that the two switches of a leg never conduct together. Every change of a leg's target state restarts a per-leg delay count. The count advances on an external timing tick. The switch being released turns off after a short turn-off delay. The switch being engaged turns on only after a longer turn-on delay. The difference between the two delays is the dead time.

Two DC motors can share the three legs in cascade: one terminal of each motor on the middle leg, the other terminals on the outer legs. Forward, reverse, brake and high impedance are all chosen with the per-switch bits. A request that turns on both switches of one leg is treated as a fault. That leg goes to high impedance and raises a per-leg error flag, which stays set until reset. The diagnosis word reports the gates actually driven, not the gates requested.

Top module: `hbdt_sequencer`

## Requirements
- R1: In every leg, the high-side and low-side gates are never high in the same cycle.
- R2: A change in a leg's request is registered on the next clock edge and clears that leg's count to zero. Each later edge with `tick` high adds one to the count. From off, the high-side gate rises on the edge after the count reaches TON_HS (default 8). With `tick` held high, this is TON_HS+1 edges after the registering edge.
- R3: Under the same rule as R2, the low-side gate turns on from off on the edge after the count reaches TON_LS (default 7).
- R4: A gate being released falls on the edge after the count reaches its turn-off delay: TOFF_HS (default 4) for the high side and TOFF_LS (default 3) for the low side.
- R5: When a leg swaps sides, the old gate falls per R4 and the new gate rises per R2/R3. Both gates stay low between those two edges, for TON_LS−TOFF_HS (3) edges on a high-to-low swap and TON_HS−TOFF_LS (5) edges on a low-to-high swap.
- R6: A request with both bits of a leg high drives that leg to high impedance, with its on gate falling per R4. On the next edge, `conflict_err` for that leg goes high. It stays high until reset, whatever the later requests are, and the flags of the other legs are not affected.
- R7: A new request made while a sequence is pending restarts the count from the current gate state. A gate that the earlier request would have turned on stays low. A gate that is already on and is requested again stays on without a glitch.
- R8: While `tick` is low, the count does not advance and the gates hold their state. The count resumes when `tick` returns high.
- R9: During and right after the synchronous active-high reset, all gates, all state bits and all error flags are low.
- R10: The legs are sequenced independently. This allows the cascade modes: forward (one outer leg high, the middle leg low), reverse (the mirror of forward), brake (both legs of a motor low) and high impedance (both legs off).
- R11: `sw_state` bit 2i is the low-side gate of leg i and bit 2i+1 is its high-side gate, matching the `sw_req` layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Delay time base; advances pending counts |
| sw_req | input | 2*LEGS | Enable request; bit 2i low side, bit 2i+1 high side of leg i |
| gate_hs | output | LEGS | High-side gate drive per leg |
| gate_ls | output | LEGS | Low-side gate drive per leg |
| sw_state | output | 2*LEGS | Actual switch state, same layout as `sw_req` |
| conflict_err | output | LEGS | Sticky flag: both switches of the leg were requested |

## Verification
Each gate edge is due a fixed number of clock edges after the stimulus. A request driven after edge n is registered at n+1. With `tick` held high, the gate then changes at edge n+T+2, where T is the delay that applies. The error flag is due one edge after the request. For each stimulus, the driver queues the expected value for the due cycle and for the cycle just before it. The monitor compares each queued item on the falling edge of the cycle it is stamped with, so both an early and a late transition are caught. The tick test counts from the edge on which `tick` is raised again, not from the request.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  // target state of one leg after request decode
  typedef enum logic [1:0] {
    TGT_OFF = 2'd0,
    TGT_LS  = 2'd1,
    TGT_HS  = 2'd2
  } leg_tgt_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hbdt_req_decode.sv
module hbdt_req_decode
  import hbdt_pkg::*;
(
  input  logic     hs_req,
  input  logic     ls_req,
  output leg_tgt_e tgt,
  output logic     conflict
);

  always_comb begin
    conflict = hs_req & ls_req;
    unique case ({hs_req, ls_req})
      2'b10:   tgt = TGT_HS;
      2'b01:   tgt = TGT_LS;
      default: tgt = TGT_OFF;  // idle or conflicting request
    endcase
  end

endmodule

// File: rtl/hbdt_leg_seq.sv
module hbdt_leg_seq
  import hbdt_pkg::*;
#(
  parameter int unsigned TON_HS  = 8,
  parameter int unsigned TOFF_HS = 4,
  parameter int unsigned TON_LS  = 7,
  parameter int unsigned TOFF_LS = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  leg_tgt_e tgt_in,
  output logic     hs_gate,
  output logic     ls_gate
);

  localparam int unsigned MAX_DLY = max4(TON_HS, TOFF_HS, TON_LS, TOFF_LS);
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 2);
  localparam logic [CNT_W-1:0] SAT      = CNT_W'(MAX_DLY);
  localparam logic [CNT_W-1:0] LIM_HSON = CNT_W'(TON_HS);
  localparam logic [CNT_W-1:0] LIM_HSOF = CNT_W'(TOFF_HS);
  localparam logic [CNT_W-1:0] LIM_LSON = CNT_W'(TON_LS);
  localparam logic [CNT_W-1:0] LIM_LSOF = CNT_W'(TOFF_LS);

  leg_tgt_e         tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hs_nxt, ls_nxt;

  // target latch and tick counter; any target change restarts the count
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= TGT_OFF;
      cnt_q <= '0;
    end else if (tgt_in != tgt_q) begin
      tgt_q <= tgt_in;
      cnt_q <= '0;
    end else if (tick && cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a gate only rises once the complementary gate is already low
  always_comb begin
    if (tgt_q == TGT_HS) hs_nxt = hs_gate | ((cnt_q >= LIM_HSON) & ~ls_gate);
    else                 hs_nxt = hs_gate & ~(cnt_q >= LIM_HSOF);
    if (tgt_q == TGT_LS) ls_nxt = ls_gate | ((cnt_q >= LIM_LSON) & ~hs_gate);
    else                 ls_nxt = ls_gate & ~(cnt_q >= LIM_LSOF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
    end else begin
      hs_gate <= hs_nxt;
      ls_gate <= ls_nxt;
    end
  end

  // R1: never both switches of the leg at once
  p_no_shoot_r1: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  // R2: high side turns on only after its on-delay elapsed on a high target
  p_hs_on_delay_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> ($past(cnt_q) >= LIM_HSON && $past(tgt_q) == TGT_HS));

  // R3: low side turns on only after its on-delay elapsed on a low target
  p_ls_on_delay_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> ($past(cnt_q) >= LIM_LSON && $past(tgt_q) == TGT_LS));

  // R4: release waits for the off-delay
  p_hs_off_delay_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hs_gate) |-> ($past(cnt_q) >= LIM_HSOF));
  p_ls_off_delay_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ls_gate) |-> ($past(cnt_q) >= LIM_LSOF));

  // R5: a gate rises only from a cycle in which the other gate was low
  p_gap_hs_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> $past(!ls_gate));
  p_gap_ls_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> $past(!hs_gate));

  // R8: without a tick and without a new request the count holds
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && tgt_in == tgt_q) |=> $stable(cnt_q));

endmodule

// File: rtl/hbdt_sequencer.sv
module hbdt_sequencer
  import hbdt_pkg::*;
#(
  parameter int unsigned LEGS    = 3,
  parameter int unsigned TON_HS  = 8,
  parameter int unsigned TOFF_HS = 4,
  parameter int unsigned TON_LS  = 7,
  parameter int unsigned TOFF_LS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [2*LEGS-1:0] sw_req,
  output logic [LEGS-1:0]   gate_hs,
  output logic [LEGS-1:0]   gate_ls,
  output logic [2*LEGS-1:0] sw_state,
  output logic [LEGS-1:0]   conflict_err
);

  logic [LEGS-1:0] conflict_now;

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    leg_tgt_e leg_tgt;

    hbdt_req_decode u_dec (
      .hs_req   (sw_req[2*i+1]),
      .ls_req   (sw_req[2*i]),
      .tgt      (leg_tgt),
      .conflict (conflict_now[i])
    );

    hbdt_leg_seq #(
      .TON_HS  (TON_HS),
      .TOFF_HS (TOFF_HS),
      .TON_LS  (TON_LS),
      .TOFF_LS (TOFF_LS)
    ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .tgt_in  (leg_tgt),
      .hs_gate (gate_hs[i]),
      .ls_gate (gate_ls[i])
    );

    // R11: diagnosis layout mirrors the request layout
    assign sw_state[2*i]   = gate_ls[i];
    assign sw_state[2*i+1] = gate_hs[i];

    // R6: a double request flags the leg on the next edge
    p_conflict_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (sw_req[2*i+1] && sw_req[2*i]) |=> conflict_err[i]);

    // R6: the flag is sticky until reset
    p_conflict_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      conflict_err[i] |=> conflict_err[i]);

    // R6: a conflicting request never leaves a gate rising
    p_conflict_no_rise_r6: assert property (@(posedge clk) disable iff (rst)
      (sw_req[2*i+1] && sw_req[2*i]) |=> !$rose(gate_hs[i]) || !$past(conflict_now[i], 2));
  end

  always_ff @(posedge clk) begin
    if (rst) conflict_err <= '0;
    else     conflict_err <= conflict_err | conflict_now;
  end

endmodule

// File: tb/hbdt_sequencer_test.sv
`timescale 1ns/1ps
module hbdt_sequencer_test;

  localparam int LEGS = 3;
  localparam int THS_ON = 8, THS_OFF = 4, TLS_ON = 7, TLS_OFF = 3;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b1;
  logic [2*LEGS-1:0] sw_req = '0;
  logic [LEGS-1:0]   gate_hs, gate_ls, conflict_err;
  logic [2*LEGS-1:0] sw_state;

  hbdt_sequencer #(.LEGS(LEGS)) uut (
    .clk(clk), .rst(rst), .tick(tick), .sw_req(sw_req),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .sw_state(sw_state),
    .conflict_err(conflict_err)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int    cyc;
    int    kind;   // 0: gates of leg, 1: error flag of leg
    int    leg;
    bit    a;      // hs gate or error flag
    bit    b;      // ls gate
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   overlap_seen = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic push(int c, int kind, int leg, bit a, bit b, string tag);
    exp_t e;
    e.cyc = c; e.kind = kind; e.leg = leg; e.a = a; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_leg(int leg, bit h, bit l);
    sw_req[2*leg+1] = h;
    sw_req[2*leg]   = l;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares queued items in the cycle they are stamped with
  always @(negedge clk) begin
    if (!rst) begin
      if ((gate_hs & gate_ls) != '0) overlap_seen = 1'b1;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          if (q[i].kind == 0) begin
            check({gate_hs[q[i].leg], gate_ls[q[i].leg]} == {q[i].a, q[i].b}, q[i].tag,
                  $sformatf("leg%0d gates {hs,ls} at cycle %0d", q[i].leg, cyc),
                  {gate_hs[q[i].leg], gate_ls[q[i].leg]}, {q[i].a, q[i].b});
            check(sw_state[2*q[i].leg +: 2] == {q[i].a, q[i].b}, "R11",
                  $sformatf("leg%0d sw_state at cycle %0d", q[i].leg, cyc),
                  sw_state[2*q[i].leg +: 2], {q[i].a, q[i].b});
          end else begin
            check(conflict_err[q[i].leg] == q[i].a, q[i].tag,
                  $sformatf("leg%0d conflict_err at cycle %0d", q[i].leg, cyc),
                  conflict_err[q[i].leg], q[i].a);
          end
          q.delete(i);
        end else if (q[i].cyc < cyc) begin
          check(1'b0, q[i].tag, "item missed", cyc, q[i].cyc);
          q.delete(i);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    int n, n2, m;
    repeat (5) @(negedge clk);
    // R9: state during reset
    check(gate_hs == '0 && gate_ls == '0, "R9", "gates in reset", {gate_hs, gate_ls}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sw_state == '0, "R9", "sw_state after reset", sw_state, 0);
    check(conflict_err == '0, "R9", "conflict_err after reset", conflict_err, 0);

    // R2: leg0 high side from off
    @(negedge clk); n = cyc; set_leg(0, 1, 0);
    push(n + THS_ON + 1, 0, 0, 0, 0, "R2");
    push(n + THS_ON + 2, 0, 0, 1, 0, "R2");
    drain();

    // R4/R5/R3: leg0 high to low swap
    @(negedge clk); n = cyc; set_leg(0, 0, 1);
    push(n + THS_OFF + 1, 0, 0, 1, 0, "R4");
    push(n + THS_OFF + 2, 0, 0, 0, 0, "R4");
    push(n + TLS_ON + 1,  0, 0, 0, 0, "R5");
    push(n + TLS_ON + 2,  0, 0, 0, 1, "R3");
    drain();

    // R5: leg0 low to high swap
    @(negedge clk); n = cyc; set_leg(0, 1, 0);
    push(n + TLS_OFF + 1, 0, 0, 0, 1, "R4");
    push(n + TLS_OFF + 2, 0, 0, 0, 0, "R4");
    push(n + THS_ON + 1,  0, 0, 0, 0, "R5");
    push(n + THS_ON + 2,  0, 0, 1, 0, "R5");
    drain();

    // R6: conflicting request on leg0
    @(negedge clk); n = cyc; set_leg(0, 1, 1);
    push(n + 1, 1, 0, 1, 0, "R6");
    push(n + 1, 1, 1, 0, 0, "R6");
    push(n + 1, 1, 2, 0, 0, "R6");
    push(n + THS_OFF + 1, 0, 0, 1, 0, "R6");
    push(n + THS_OFF + 2, 0, 0, 0, 0, "R6");
    push(n + 20, 0, 0, 0, 0, "R6");
    drain();
    @(negedge clk); n = cyc; set_leg(0, 0, 0);
    push(n + 5, 1, 0, 1, 0, "R6");
    drain();

    // R10: forward on motor legs 1/2
    @(negedge clk); n = cyc; set_leg(1, 1, 0); set_leg(2, 0, 1);
    push(n + TLS_ON + 2, 0, 2, 0, 1, "R10");
    push(n + THS_ON + 2, 0, 1, 1, 0, "R10");
    push(n + THS_ON + 2, 0, 0, 0, 0, "R10");
    drain();
    // reverse
    @(negedge clk); n = cyc; set_leg(1, 0, 1); set_leg(2, 1, 0);
    push(n + TLS_OFF + 2, 0, 2, 0, 0, "R10");
    push(n + THS_OFF + 2, 0, 1, 0, 0, "R10");
    push(n + TLS_ON + 2,  0, 1, 0, 1, "R10");
    push(n + THS_ON + 2,  0, 2, 1, 0, "R10");
    drain();
    // brake: both low
    @(negedge clk); n = cyc; set_leg(2, 0, 1);
    push(n + TLS_ON + 2, 0, 2, 0, 1, "R10");
    push(n + TLS_ON + 2, 0, 1, 0, 1, "R10");
    drain();
    // high impedance
    @(negedge clk); n = cyc; set_leg(1, 0, 0); set_leg(2, 0, 0);
    push(n + TLS_OFF + 2, 0, 1, 0, 0, "R10");
    push(n + TLS_OFF + 2, 0, 2, 0, 0, "R10");
    drain();

    // R7: restart before the high side would rise
    @(negedge clk); n = cyc; set_leg(1, 1, 0);
    repeat (3) @(negedge clk); n2 = cyc; set_leg(1, 0, 1);
    push(n + THS_ON + 2,  0, 1, 0, 0, "R7");
    push(n2 + TLS_ON + 1, 0, 1, 0, 0, "R7");
    push(n2 + TLS_ON + 2, 0, 1, 0, 1, "R7");
    drain();
    // R7: re-request a gate that is still on before its release
    @(negedge clk); n = cyc; set_leg(1, 0, 0);
    repeat (2) @(negedge clk); set_leg(1, 0, 1);
    push(n + TLS_OFF + 2, 0, 1, 0, 1, "R7");
    push(n + 15, 0, 1, 0, 1, "R7");
    drain();

    // R8: no ticks, no progress
    @(negedge clk); tick = 1'b0; n = cyc; set_leg(2, 1, 0);
    push(n + THS_ON + 2, 0, 2, 0, 0, "R8");
    push(n + 20, 0, 2, 0, 0, "R8");
    drain();
    @(negedge clk); m = cyc; tick = 1'b1;
    push(m + THS_ON,     0, 2, 0, 0, "R8");
    push(m + THS_ON + 1, 0, 2, 1, 0, "R8");
    drain();

    // R1: overlap never observed; R6: flags at end
    check(!overlap_seen, "R1", "both gates of a leg high", overlap_seen, 0);
    check(conflict_err == 3'b001, "R6", "final conflict flags", conflict_err, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule